// File: doc/BRIEF.md
# Fast-to-Slow Peripheral Bus Bridge

This block lets a fast processor reach an 8-bit peripheral bus that runs at half its clock and speaks classic 8-bit microprocessor strobes: I/O request, read, write and opcode-fetch (M1), all active low. The bridge makes the peripheral bus clock with a single toggle flop. At the clock edge that accepts a transfer it forces that flop to a fixed phase, so strobes always land at the same point of the slow clock. While a transfer runs it holds the host in wait, which stretches the host cycle to exactly one slow-bus machine cycle of `T_STATES` slow clocks.

The top eight bits of the 24-bit host I/O address select a page. One page maps straight onto the 256 peripheral bus addresses. A second page holds local on-board I/O, and one port in it is owned by the bridge. Every other page, including the two that belong to the processor's own registers, is left alone. Vectored interrupts from daisy-chained peripherals work in both directions. An acknowledge cycle asserts M1 and I/O request together and returns the vector byte. An access to the owned local port plays out two opcode-fetch cycles carrying the return-from-interrupt byte pair, so the peripherals release their in-service state.

Top module: `slowbus_bridge`

## Requirements
- R1: `bus_clk` is 0 while `rst` is high and inverts on every `clk` edge, except the edge that accepts a transfer.
- R2: The edge that accepts a transfer sets `bus_clk` to 1. Inside a transfer, `bus_clk` is 1 at even cycle offsets and 0 at odd ones, where offset 0 is the first cycle with `host_wait` high.
- R3: An accepted read, write or acknowledge holds `host_wait` high for exactly 2*`T_STATES` cycles (8 by default). `host_done` is high only in the last of those cycles. A return-from-interrupt holds `host_wait` for 4*`T_STATES` cycles.
- R4: A read (`host_kind`=0) to the bus page drives `bus_iorq_n` and `bus_rd_n` low at offsets 1 to 2*`T_STATES`-2. The byte on `bus_din` at offset 2*`T_STATES`-2 appears on both halves of `host_rdata` while `host_done` is high.
- R5: A write (`host_kind`=1) to the bus page drives `bus_iorq_n` and `bus_wr_n` low over the same offsets and holds `bus_doe` high for the whole transfer. `bus_dout` carries `host_wdata[15:8]` when `host_addr[0]`=1 and `host_wdata[7:0]` when it is 0.
- R6: An acknowledge (`host_kind`=2), whatever the address, drives `bus_m1_n` and `bus_iorq_n` low together over the strobe offsets, with read and write high. The vector byte from `bus_din` returns on both halves of `host_rdata`.
- R7: Page `host_addr[23:16]`=0x80 is the bus page, and `bus_addr` carries `host_addr[7:0]` during its transfers. A read or write to any other page (0xFE and 0xFF included), to a local-page port other than the owned one, or with `host_kind`=3 is ignored: `host_wait`, `host_done` and every strobe stay inactive.
- R8: A read or write to local page 0x81, port 0xF0, runs two back-to-back fetch phases, each 2*`T_STATES` cycles long. In each phase `bus_m1_n` and `bus_rd_n` are low at the strobe offsets and `bus_iorq_n` stays high. `bus_doe` is high throughout, and `bus_dout` is 0xED in the first phase and 0x4D in the second.
- R9: A request still held when `host_done` is high is accepted only after one full cycle with `host_wait` low and every strobe high, so two back-to-back transfers have their `host_done` cycles 2*`T_STATES`+1 cycles apart.
- R10: While `rst` is high, all strobes are high, and `host_wait`, `host_done`, `bus_doe`, `bus_dout`, `bus_addr` and `host_rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host I/O request, held until `host_done` |
| host_kind | input | 2 | 0 read, 1 write, 2 interrupt acknowledge, 3 none |
| host_addr | input | 24 | Host I/O address; bits 23:16 are the page |
| host_wdata | input | 16 | Host write data, lane chosen by address bit 0 |
| host_wait | output | 1 | Wait request to the host while a transfer runs |
| host_done | output | 1 | Last cycle of a transfer |
| host_rdata | output | 16 | Read or vector byte, duplicated on both lanes |
| bus_clk | output | 1 | Peripheral bus clock, host clock divided by two |
| bus_iorq_n | output | 1 | Peripheral I/O request strobe, active low |
| bus_rd_n | output | 1 | Peripheral read strobe, active low |
| bus_wr_n | output | 1 | Peripheral write strobe, active low |
| bus_m1_n | output | 1 | Peripheral opcode-fetch marker, active low |
| bus_addr | output | 8 | Peripheral bus address |
| bus_dout | output | 8 | Data driven onto the peripheral bus |
| bus_doe | output | 1 | Output enable for `bus_dout` |
| bus_din | input | 8 | Data read from the peripheral bus |

## Verification
Two functions collide in a single cycle: the free-running halving of the clock and the phase force at transfer acceptance. When the flop already holds 1 at the accepting edge, the force overrides the toggle. The bench provokes both outcomes by separating requests with odd and even idle gaps. A second collision comes from keeping a request asserted through `host_done`, so that transfer completion and the next acceptance compete for adjacent edges. A behavioural model predicts `bus_clk`, every strobe, the data lanes and the returned bytes on each cycle. The bench compares the design against it and measures the spacing between completions.

// File: rtl/sbb_pkg.sv
package sbb_pkg;

    localparam int DW     = 8;
    localparam int BUS_AW = 8;

    typedef enum logic [1:0] {
        KIND_RD   = 2'd0,
        KIND_WR   = 2'd1,
        KIND_INTA = 2'd2,
        KIND_NONE = 2'd3
    } host_kind_e;

    typedef enum logic [1:0] {
        OP_IORD = 2'd0,
        OP_IOWR = 2'd1,
        OP_INTA = 2'd2,
        OP_RETI = 2'd3
    } bridge_op_e;

    typedef struct packed {
        logic       hit;
        bridge_op_e op;
    } decode_t;

    typedef struct packed {
        bridge_op_e        op;
        logic [BUS_AW-1:0] addr;
        logic [DW-1:0]     wbyte;
    } xfer_t;

    localparam logic [DW-1:0] FETCH_BYTE0 = 8'hED;
    localparam logic [DW-1:0] FETCH_BYTE1 = 8'h4D;

    function automatic logic [DW-1:0] lane_pick(input logic hi, input logic [2*DW-1:0] w);
        return hi ? w[2*DW-1:DW] : w[DW-1:0];
    endfunction

    function automatic logic op_is_io(input bridge_op_e op);
        return (op == OP_IORD) || (op == OP_IOWR);
    endfunction

endpackage

// File: rtl/sbb_page_decode.sv
module sbb_page_decode
    import sbb_pkg::*;
#(
    parameter int                ADDR_W     = 24,
    parameter int                PAGE_W     = 8,
    parameter logic [PAGE_W-1:0] PAGE_EXT   = 'h80,
    parameter logic [PAGE_W-1:0] PAGE_LOCAL = 'h81,
    parameter logic [BUS_AW-1:0] RETI_PORT  = 'hF0
) (
    input  logic [1:0]        kind,
    input  logic [ADDR_W-1:0] addr,
    output decode_t           dec
);
    localparam int PAGE_LSB = ADDR_W - PAGE_W;

    logic [PAGE_W-1:0] page;
    logic              rd_or_wr;

    assign page     = addr[ADDR_W-1:PAGE_LSB];
    assign rd_or_wr = (kind == KIND_RD) || (kind == KIND_WR);

    always_comb begin
        dec.hit = 1'b0;
        dec.op  = OP_IORD;
        if (kind == KIND_INTA) begin
            dec.hit = 1'b1;
            dec.op  = OP_INTA;
        end else if (rd_or_wr && page == PAGE_EXT) begin
            dec.hit = 1'b1;
            dec.op  = (kind == KIND_WR) ? OP_IOWR : OP_IORD;
        end else if (rd_or_wr && page == PAGE_LOCAL && addr[BUS_AW-1:0] == RETI_PORT) begin
            dec.hit = 1'b1;
            dec.op  = OP_RETI;
        end
    end

endmodule

// File: rtl/sbb_clk_div.sv
module sbb_clk_div (
    input  logic clk,
    input  logic rst,
    input  logic align,
    output logic bclk
);
    always_ff @(posedge clk) begin
        if (rst)        bclk <= 1'b0;
        else if (align) bclk <= 1'b1;
        else            bclk <= ~bclk;
    end
endmodule

// File: rtl/sbb_sequencer.sv
module sbb_sequencer
    import sbb_pkg::*;
#(
    parameter int T_STATES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  xfer_t             xin,
    input  logic [DW-1:0]     din,
    output logic              idle,
    output logic              done,
    output logic              iorq_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic              m1_n,
    output logic              doe,
    output logic [DW-1:0]     dout,
    output logic [BUS_AW-1:0] baddr,
    output logic [2*DW-1:0]   rdata
);
    localparam int CYC      = 2 * T_STATES;
    localparam int CNT_W    = $clog2(CYC);
    localparam int LAST     = CYC - 1;
    localparam int STB_LAST = CYC - 2;

    logic             busy;
    logic             second;
    logic [CNT_W-1:0] cnt;
    xfer_t            cur;
    logic             at_last;
    logic             win;
    logic             captures;

    assign at_last  = (cnt == CNT_W'(LAST));
    assign captures = (cur.op == OP_IORD) || (cur.op == OP_INTA);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            second <= 1'b0;
            cnt    <= '0;
            cur    <= '0;
            rdata  <= '0;
        end else if (!busy) begin
            if (start) begin
                busy   <= 1'b1;
                second <= 1'b0;
                cnt    <= '0;
                cur    <= xin;
            end
        end else begin
            if (at_last) begin
                cnt <= '0;
                if (cur.op == OP_RETI && !second) second <= 1'b1;
                else                              busy   <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
            if (cnt == CNT_W'(STB_LAST) && captures)
                rdata <= {din, din};
        end
    end

    assign idle = !busy;
    assign win  = busy && (cnt != '0) && !at_last;
    assign done = busy && at_last && ((cur.op != OP_RETI) || second);

    assign iorq_n = !(win && (cur.op != OP_RETI));
    assign rd_n   = !(win && (cur.op == OP_IORD || cur.op == OP_RETI));
    assign wr_n   = !(win && (cur.op == OP_IOWR));
    assign m1_n   = !(win && (cur.op == OP_INTA || cur.op == OP_RETI));
    assign doe    = busy && (cur.op == OP_IOWR || cur.op == OP_RETI);
    assign baddr  = busy ? cur.addr : '0;

    always_comb begin
        dout = '0;
        if (busy) begin
            if (cur.op == OP_IOWR)      dout = cur.wbyte;
            else if (cur.op == OP_RETI) dout = second ? FETCH_BYTE1 : FETCH_BYTE0;
        end
    end

endmodule

// File: rtl/slowbus_bridge.sv
module slowbus_bridge
    import sbb_pkg::*;
#(
    parameter int                ADDR_W     = 24,
    parameter int                PAGE_W     = 8,
    parameter int                T_STATES   = 4,
    parameter logic [PAGE_W-1:0] PAGE_EXT   = 'h80,
    parameter logic [PAGE_W-1:0] PAGE_LOCAL = 'h81,
    parameter logic [BUS_AW-1:0] RETI_PORT  = 'hF0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_req,
    input  logic [1:0]        host_kind,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [2*DW-1:0]   host_wdata,
    output logic              host_wait,
    output logic              host_done,
    output logic [2*DW-1:0]   host_rdata,
    output logic              bus_clk,
    output logic              bus_iorq_n,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    output logic              bus_m1_n,
    output logic [BUS_AW-1:0] bus_addr,
    output logic [DW-1:0]     bus_dout,
    output logic              bus_doe,
    input  logic [DW-1:0]     bus_din
);
    decode_t dec;
    xfer_t   xin;
    logic    idle;
    logic    start;

    sbb_page_decode #(
        .ADDR_W    (ADDR_W),
        .PAGE_W    (PAGE_W),
        .PAGE_EXT  (PAGE_EXT),
        .PAGE_LOCAL(PAGE_LOCAL),
        .RETI_PORT (RETI_PORT)
    ) u_decode (
        .kind(host_kind),
        .addr(host_addr),
        .dec (dec)
    );

    always_comb begin
        xin.op    = dec.op;
        xin.addr  = op_is_io(dec.op) ? host_addr[BUS_AW-1:0] : '0;
        xin.wbyte = lane_pick(host_addr[0], host_wdata);
    end

    assign start = host_req && dec.hit && idle;

    sbb_clk_div u_div (
        .clk  (clk),
        .rst  (rst),
        .align(start),
        .bclk (bus_clk)
    );

    sbb_sequencer #(
        .T_STATES(T_STATES)
    ) u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .xin   (xin),
        .din   (bus_din),
        .idle  (idle),
        .done  (host_done),
        .iorq_n(bus_iorq_n),
        .rd_n  (bus_rd_n),
        .wr_n  (bus_wr_n),
        .m1_n  (bus_m1_n),
        .doe   (bus_doe),
        .dout  (bus_dout),
        .baddr (bus_addr),
        .rdata (host_rdata)
    );

    assign host_wait = !idle;

endmodule

// File: rtl/sbb_bridge_chk.sv
module sbb_bridge_chk (
    input logic clk,
    input logic rst,
    input logic host_wait,
    input logic host_done,
    input logic bus_clk,
    input logic bus_iorq_n,
    input logic bus_rd_n,
    input logic bus_wr_n,
    input logic bus_m1_n,
    input logic bus_doe
);
    logic armed;

    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    AST_CLK_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (armed && !$rose(host_wait)) |-> (bus_clk != $past(bus_clk))); // R1
    AST_PHASE_LOCK: assert property (@(posedge clk) disable iff (rst)
        $rose(host_wait) |-> bus_clk); // R2
    AST_STROBE_IN_WAIT: assert property (@(posedge clk) disable iff (rst)
        (!bus_iorq_n || !bus_rd_n || !bus_wr_n || !bus_m1_n) |-> host_wait); // R3
    AST_DONE_IN_WAIT: assert property (@(posedge clk) disable iff (rst)
        host_done |-> host_wait); // R3
    AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        host_done |=> !host_wait); // R3
    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !bus_rd_n |-> bus_wr_n); // R4
    AST_WR_DRIVES: assert property (@(posedge clk) disable iff (rst)
        !bus_wr_n |-> bus_doe); // R5
    AST_ACK_PAIR: assert property (@(posedge clk) disable iff (rst)
        (!bus_m1_n && !bus_iorq_n) |-> (bus_rd_n && bus_wr_n)); // R6
    AST_FETCH_NO_IORQ: assert property (@(posedge clk) disable iff (rst)
        (!bus_m1_n && !bus_rd_n) |-> (bus_iorq_n && bus_doe)); // R8
    AST_GAP_QUIET: assert property (@(posedge clk) disable iff (rst)
        host_done |=> (bus_iorq_n && bus_rd_n && bus_wr_n && bus_m1_n)); // R9

endmodule

bind slowbus_bridge sbb_bridge_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .host_wait (host_wait),
    .host_done (host_done),
    .bus_clk   (bus_clk),
    .bus_iorq_n(bus_iorq_n),
    .bus_rd_n  (bus_rd_n),
    .bus_wr_n  (bus_wr_n),
    .bus_m1_n  (bus_m1_n),
    .bus_doe   (bus_doe)
);

// File: tb/tb_slowbus_bridge.sv
`timescale 1ns/1ps
module tb_slowbus_bridge;

    localparam int TS  = 4;
    localparam int LEN = 2 * TS;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_req = 1'b0;
    logic [1:0]  host_kind = 2'd0;
    logic [23:0] host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic        host_wait, host_done;
    logic [15:0] host_rdata;
    logic        bus_clk, bus_iorq_n, bus_rd_n, bus_wr_n, bus_m1_n, bus_doe;
    logic [7:0]  bus_addr, bus_dout, bus_din;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;
    logic [7:0] int_vec = 8'h00;

    always #5 clk = ~clk;

    slowbus_bridge dut (
        .clk(clk), .rst(rst), .host_req(host_req), .host_kind(host_kind),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_wait(host_wait),
        .host_done(host_done), .host_rdata(host_rdata), .bus_clk(bus_clk),
        .bus_iorq_n(bus_iorq_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
        .bus_m1_n(bus_m1_n), .bus_addr(bus_addr), .bus_dout(bus_dout),
        .bus_doe(bus_doe), .bus_din(bus_din)
    );

    function automatic logic [7:0] port_byte(input logic [7:0] a);
        return a ^ 8'h5A;
    endfunction

    // Peripheral model: vector on acknowledge, port pattern on read.
    assign bus_din = (!bus_m1_n && !bus_iorq_n) ? int_vec :
                     (!bus_iorq_n && !bus_rd_n) ? port_byte(bus_addr) : 8'hFF;

    typedef struct packed {
        logic        wt, dn, iorq_n, rd_n, wr_n, m1_n, doe;
        logic [7:0]  dout, addr;
        logic        rchk;
        logic [15:0] rexp;
    } exp_t;

    localparam exp_t IDLE_E = '{wt:1'b0, dn:1'b0, iorq_n:1'b1, rd_n:1'b1, wr_n:1'b1,
                               m1_n:1'b1, doe:1'b0, dout:8'h00, addr:8'h00,
                               rchk:1'b0, rexp:16'h0000};

    exp_t q[$];
    exp_t cur = IDLE_E;
    logic m_bclk = 1'b0;
    logic started = 1'b0;

    // -1 ignored, 0 read, 1 write, 2 acknowledge, 3 return-from-interrupt
    function automatic int op_of(input logic [1:0] k, input logic [23:0] a);
        if (k == 2'd2) return 2;
        if (k == 2'd3) return -1;
        if (a[23:16] == 8'h80) return (k == 2'd1) ? 1 : 0;
        if (a[23:16] == 8'h81 && a[7:0] == 8'hF0) return 3;
        return -1;
    endfunction

    task automatic build(input int op, input logic [23:0] a, input logic [15:0] w);
        int phases = (op == 3) ? 2 : 1;
        for (int ph = 0; ph < phases; ph++) begin
            for (int c = 0; c < LEN; c++) begin
                exp_t e;
                logic win = (c >= 1) && (c <= LEN - 2);
                e.wt     = 1'b1;
                e.dn     = (c == LEN - 1) && (ph == phases - 1);
                e.iorq_n = !(win && op != 3);
                e.rd_n   = !(win && (op == 0 || op == 3));
                e.wr_n   = !(win && op == 1);
                e.m1_n   = !(win && (op == 2 || op == 3));
                e.doe    = (op == 1 || op == 3);
                e.dout   = (op == 1) ? (a[0] ? w[15:8] : w[7:0]) :
                           (op == 3) ? ((ph == 1) ? 8'h4D : 8'hED) : 8'h00;
                e.addr   = (op <= 1) ? a[7:0] : 8'h00;
                e.rchk   = e.dn && (op == 0 || op == 2);
                e.rexp   = (op == 0) ? {2{port_byte(a[7:0])}} : {2{int_vec}};
                q.push_back(e);
            end
        end
    endtask

    // Reference model advances on the same edge as the design.
    always @(posedge clk) begin
        int op;
        cyc++;
        started = 1'b1;
        if (rst) begin
            q.delete();
            cur = IDLE_E;
            m_bclk = 1'b0;
        end else begin
            op = op_of(host_kind, host_addr);
            if (q.size() == 0 && !cur.wt && host_req && op >= 0) begin
                build(op, host_addr, host_wdata);
                cur = q.pop_front();
                m_bclk = 1'b1;
            end else begin
                if (q.size() > 0) cur = q.pop_front();
                else              cur = IDLE_E;
                m_bclk = ~m_bclk;
            end
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h at cycle %0d", req, what, act, exp, cyc);
        end
    endtask

    logic [7:0]  last_wr = 8'h00;
    logic [15:0] fetch_pair = 16'h0000;
    logic        prev_fetch = 1'b0;
    int          reti_seen = 0;

    always @(negedge clk) begin
        if (started) begin
            chk("R1/R2", "bus_clk", {15'd0, bus_clk}, {15'd0, m_bclk});
            chk("R3", "host_wait", {15'd0, host_wait}, {15'd0, cur.wt});
            chk("R3", "host_done", {15'd0, host_done}, {15'd0, cur.dn});
            chk("R4", "bus_iorq_n", {15'd0, bus_iorq_n}, {15'd0, cur.iorq_n});
            chk("R4", "bus_rd_n", {15'd0, bus_rd_n}, {15'd0, cur.rd_n});
            chk("R5", "bus_wr_n", {15'd0, bus_wr_n}, {15'd0, cur.wr_n});
            chk("R6", "bus_m1_n", {15'd0, bus_m1_n}, {15'd0, cur.m1_n});
            chk("R5", "bus_doe", {15'd0, bus_doe}, {15'd0, cur.doe});
            chk("R8", "bus_dout", {8'd0, bus_dout}, {8'd0, cur.dout});
            chk("R7", "bus_addr", {8'd0, bus_addr}, {8'd0, cur.addr});
            if (cur.rchk) chk("R4/R6", "host_rdata", host_rdata, cur.rexp);
            if (!bus_wr_n) last_wr = bus_dout;
            if (!bus_m1_n && !bus_rd_n && !prev_fetch) begin
                fetch_pair = {fetch_pair[7:0], bus_dout};
                if (fetch_pair == 16'hED4D) reti_seen++;
            end
            prev_fetch = !bus_m1_n && !bus_rd_n;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic xfer(input logic [1:0] k, input logic [23:0] a, input logic [15:0] w);
        host_kind = k; host_addr = a; host_wdata = w; host_req = 1'b1;
        do @(negedge clk); while (!host_done);
        host_req = 1'b0;
    endtask

    task automatic ignored(input logic [1:0] k, input logic [23:0] a);
        host_kind = k; host_addr = a; host_wdata = 16'hA5A5; host_req = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            chk("R7", "ignored request wait", {15'd0, host_wait}, 16'd0);
        end
        host_req = 1'b0;
    endtask

    initial begin
        #500000;
        fails++;
        $display("FAIL R3 watchdog expired actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int d1, d2, r0;
        idle(2);
        // R10: reset state
        chk("R10", "reset host_wait", {15'd0, host_wait}, 16'd0);
        chk("R10", "reset strobes", {12'd0, bus_iorq_n, bus_rd_n, bus_wr_n, bus_m1_n}, 16'h000F);
        chk("R10", "reset bus_clk", {15'd0, bus_clk}, 16'd0);
        chk("R10", "reset host_rdata", host_rdata, 16'h0000);
        chk("R10", "reset bus_doe", {15'd0, bus_doe}, 16'd0);
        idle(1);
        rst = 1'b0;
        idle(3);

        // R4 R7: reads at both divider parities (R2)
        xfer(2'd0, 24'h800012, 16'h0);
        chk("R4", "read return", host_rdata, {2{port_byte(8'h12)}});
        idle(2);
        xfer(2'd0, 24'h8000A5, 16'h0);
        idle(1);

        // R5: lane select
        xfer(2'd1, 24'h800031, 16'hBEEF);
        chk("R5", "upper lane byte", {8'd0, last_wr}, 16'h00BE);
        idle(4);
        xfer(2'd1, 24'h800030, 16'h1234);
        chk("R5", "lower lane byte", {8'd0, last_wr}, 16'h0034);
        idle(3);

        // R6: acknowledge on a reserved page address still runs
        int_vec = 8'h3C;
        xfer(2'd2, 24'hFE0000, 16'h0);
        chk("R6", "vector return", host_rdata, 16'h3C3C);
        idle(2);

        // R8: return-from-interrupt via write and via read
        r0 = reti_seen;
        xfer(2'd1, 24'h8100F0, 16'h0);
        chk("R8", "fetch pair seen by write", reti_seen - r0, 1);
        idle(1);
        xfer(2'd0, 24'h8100F0, 16'h0);
        chk("R8", "fetch pair seen by read", reti_seen - r0, 2);
        idle(2);

        // R7: ignored pages, ports and kind
        ignored(2'd0, 24'hFE0010);
        ignored(2'd1, 24'hFF0020);
        ignored(2'd0, 24'h810010);
        ignored(2'd3, 24'h800010);
        idle(1);

        // R9: request held through done
        host_kind = 2'd0; host_addr = 24'h800077; host_req = 1'b1;
        do @(negedge clk); while (!host_done);
        d1 = cyc;
        do @(negedge clk); while (!host_done);
        d2 = cyc;
        host_req = 1'b0;
        chk("R9", "done spacing", d2 - d1, LEN + 1);
        idle(5);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule